// File: doc/BRIEF.md
# Switch Bank Enable and Diagnosis Logic

This block sits between the serial command decoder and the gate drivers of a sixteen-channel low-side switch bank. It produces one gate-enable per channel. On eight of the channels, the enable comes from a serial command bit together with a dedicated parallel pin. On the other eight channels, the serial command bit alone sets the enable.

A mode register sets how the parallel pin and the serial bit combine: either AND or OR. Protection flags arrive from the analog comparators as digital levels. Overtemperature and supply undervoltage force gates off. The block also condenses each channel's protection flags into a two-bit diagnosis code, which the serial interface reads in two words of eight channels each. Any channel that is not in the normal state pulls the shared active-low fault output low.

Overcurrent arrives as two comparator levels, an upper threshold and a lower threshold, and the block derives a hysteresis state from them. Overload and short-to-ground codes stay latched until the serial interface reads the word that holds them, so a short event is not lost between reads.

Top module: `switch_bank_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it drops, every gate enable is 0, every diagnosis code is 2'b11, and `fault_n` is 1. The combining mode comes out of reset as OR.
- R2: Channels 5–8 and 13–16 (indices 4–7 and 12–15) drive their gate enable from `spi_cmd` alone. `par_in` has no effect on them.
- R3: In OR mode, the gate of a channel with a parallel pin is `spi_cmd | par_in`. Channels 1–4 (indices 0–3) use `par_in[0..3]`, and channels 9–12 (indices 8–11) use `par_in[4..7]`.
- R4: A cycle with `mode_wr` high loads the mode: `mode_val` = 1 selects AND, 0 selects OR. The new mode governs the gate value computed at the following clock edge.
- R5: `ot_flag[i]` high forces gate i off and reports overload (2'b10). Once the flag is low at an edge, the gate follows its command again at that edge.
- R6: `uv_flag` high forces all sixteen gates off.
- R7: For each channel, an overcurrent state is set while `oc_hi` is high, cleared while `oc_lo` is low, and held otherwise. Overcurrent state reports overload (2'b10).
- R8: Codes are 2'b11 normal, 2'b10 overload, 2'b00 short to ground, 2'b01 open load. When several conditions are present, overload wins over short to ground, which wins over open load.
- R9: Overload and short-to-ground conditions stay latched until a cycle with `diag_rd` high and `diag_grp` equal to the channel's group: 0 for channels 1–8, 1 for channels 9–16. A condition that is still live at that read keeps its code. A read of the other group has no effect.
- R10: Open load is not latched. The code returns to normal at the edge where `ol_flag` is low.
- R11: `fault_n` is 0 exactly when at least one diagnosis code is not 2'b11.
- R12: Gate enables and codes are registered. A change at the inputs shows at the outputs after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cmd | input | 16 | Serial command bit per channel |
| par_in | input | 8 | Parallel control pins for channels 1–4 and 9–12 |
| mode_wr | input | 1 | Load strobe for the combining mode |
| mode_val | input | 1 | Mode to load: 1 = AND, 0 = OR |
| uv_flag | input | 1 | Supply undervoltage |
| ot_flag | input | 16 | Overtemperature per channel |
| oc_hi | input | 16 | Current above upper overcurrent threshold |
| oc_lo | input | 16 | Current above lower overcurrent threshold |
| sg_flag | input | 16 | Short to ground per channel |
| ol_flag | input | 16 | Open load per channel |
| diag_rd | input | 1 | Diagnosis word read strobe |
| diag_grp | input | 1 | Group being read: 0 = channels 1–8, 1 = channels 9–16 |
| gate_en | output | 16 | Gate enable per channel |
| diag_code | output | 32 | Two-bit code per channel; channel index i at bits 2i+1:2i |
| fault_n | output | 1 | Active-low common fault |

## Verification
Every gate enable and diagnosis code is due at the first rising edge after its inputs are applied. `fault_n` follows the codes within that same cycle. A mode write affects gates from the edge after the one that stores it. The bench therefore drives inputs at the falling edge and advances its reference at the rising edge, using the inputs and mode it held before that edge. It compares all outputs at the next falling edge. One directed check also confirms that outputs have not moved before the edge.

// File: rtl/swb_pkg.sv
`timescale 1ns/1ps
package swb_pkg;

    localparam int CH_PER_GRP  = 8;
    localparam int PAR_PER_GRP = 4;

    typedef enum logic [1:0] {
        DG_SHORT_GND = 2'b00,
        DG_OPEN_LOAD = 2'b01,
        DG_OVERLOAD  = 2'b10,
        DG_NORMAL    = 2'b11
    } diag_e;

    typedef enum logic {
        MIX_OR  = 1'b0,
        MIX_AND = 1'b1
    } mix_e;

    typedef struct packed {
        logic cmd;     // command after mixing
        logic uv;      // supply undervoltage
        logic ot;      // overtemperature
        logic oc_hi;   // above upper current threshold
        logic oc_lo;   // above lower current threshold
        logic sg;      // short to ground
        logic ol;      // open load
        logic clr;     // read of this channel's diagnosis word
    } ch_in_t;

    function automatic bit ch_has_par(input int ch);
        return (ch % CH_PER_GRP) < PAR_PER_GRP;
    endfunction

    function automatic int ch_par_idx(input int ch);
        return (ch / CH_PER_GRP) * PAR_PER_GRP + (ch % CH_PER_GRP);
    endfunction

    function automatic logic mix_cmd(input mix_e m, input logic s, input logic p);
        return (m == MIX_AND) ? (s & p) : (s | p);
    endfunction

    function automatic diag_e encode_diag(input logic ovl, input logic sg, input logic ol);
        if (ovl)     return DG_OVERLOAD;
        else if (sg) return DG_SHORT_GND;
        else if (ol) return DG_OPEN_LOAD;
        else         return DG_NORMAL;
    endfunction

endpackage

// File: rtl/swb_mix_mode.sv
`timescale 1ns/1ps
module swb_mix_mode
    import swb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic val,
    output mix_e mode
);

    always_ff @(posedge clk) begin
        if (rst)     mode <= MIX_OR;
        else if (wr) mode <= mix_e'(val);
    end

endmodule

// File: rtl/swb_channel.sv
`timescale 1ns/1ps
module swb_channel
    import swb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ch_in_t cin,
    output logic   gate,
    output diag_e  code
);

    logic oc_q, ovl_q, sg_q;
    logic oc_d, ovl_d, sg_d;

    always_comb begin
        // hysteresis: set above upper, clear below lower, hold between
        if (cin.oc_hi)      oc_d = 1'b1;
        else if (!cin.oc_lo) oc_d = 1'b0;
        else                oc_d = oc_q;
        // sticky reports; a live condition beats the read clear
        ovl_d = oc_d | cin.ot | (ovl_q & ~cin.clr);
        sg_d  = cin.sg | (sg_q & ~cin.clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oc_q  <= 1'b0;
            ovl_q <= 1'b0;
            sg_q  <= 1'b0;
            gate  <= 1'b0;
            code  <= DG_NORMAL;
        end else begin
            oc_q  <= oc_d;
            ovl_q <= ovl_d;
            sg_q  <= sg_d;
            gate  <= cin.cmd & ~cin.ot & ~cin.uv;
            code  <= encode_diag(ovl_d, sg_d, cin.ol);
        end
    end

endmodule

// File: rtl/swb_fault_merge.sv
`timescale 1ns/1ps
module swb_fault_merge
    import swb_pkg::*;
#(
    parameter int N_CH = 16
) (
    input  logic [2*N_CH-1:0] codes,
    output logic              fault_n
);

    logic [N_CH-1:0] bad;

    for (genvar i = 0; i < N_CH; i++) begin : g_bad
        assign bad[i] = (codes[2*i +: 2] != DG_NORMAL);
    end

    assign fault_n = ~|bad;

endmodule

// File: rtl/switch_bank_ctrl.sv
`timescale 1ns/1ps
module switch_bank_ctrl
    import swb_pkg::*;
#(
    parameter  int N_CH  = 16,
    localparam int N_GRP = N_CH / CH_PER_GRP,
    localparam int N_PAR = N_GRP * PAR_PER_GRP,
    localparam int GRP_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CH-1:0]   spi_cmd,
    input  logic [N_PAR-1:0]  par_in,
    input  logic              mode_wr,
    input  logic              mode_val,
    input  logic              uv_flag,
    input  logic [N_CH-1:0]   ot_flag,
    input  logic [N_CH-1:0]   oc_hi,
    input  logic [N_CH-1:0]   oc_lo,
    input  logic [N_CH-1:0]   sg_flag,
    input  logic [N_CH-1:0]   ol_flag,
    input  logic              diag_rd,
    input  logic [GRP_W-1:0]  diag_grp,
    output logic [N_CH-1:0]   gate_en,
    output logic [2*N_CH-1:0] diag_code,
    output logic              fault_n
);

    mix_e mode_q;
    logic mode_and;

    swb_mix_mode u_mode (
        .clk  (clk),
        .rst  (rst),
        .wr   (mode_wr),
        .val  (mode_val),
        .mode (mode_q)
    );

    assign mode_and = (mode_q == MIX_AND);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic   cmd_w;
        ch_in_t cin;
        diag_e  code_w;

        if (ch_has_par(i)) begin : g_mix
            assign cmd_w = mix_cmd(mode_q, spi_cmd[i], par_in[ch_par_idx(i)]);
        end else begin : g_direct
            assign cmd_w = spi_cmd[i];
        end

        assign cin = '{
            cmd:   cmd_w,
            uv:    uv_flag,
            ot:    ot_flag[i],
            oc_hi: oc_hi[i],
            oc_lo: oc_lo[i],
            sg:    sg_flag[i],
            ol:    ol_flag[i],
            clr:   diag_rd && (int'(diag_grp) == (i / CH_PER_GRP))
        };

        swb_channel u_chan (
            .clk  (clk),
            .rst  (rst),
            .cin  (cin),
            .gate (gate_en[i]),
            .code (code_w)
        );

        assign diag_code[2*i +: 2] = code_w;
    end

    swb_fault_merge #(.N_CH(N_CH)) u_fault (
        .codes   (diag_code),
        .fault_n (fault_n)
    );

endmodule

// File: rtl/swb_checker.sv
`timescale 1ns/1ps
module swb_checker
    import swb_pkg::*;
#(
    parameter int N_CH = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [N_CH-1:0]   spi_cmd,
    input logic              uv_flag,
    input logic [N_CH-1:0]   ot_flag,
    input logic [N_CH-1:0]   oc_hi,
    input logic [N_CH-1:0]   sg_flag,
    input logic [N_CH-1:0]   gate_en,
    input logic [2*N_CH-1:0] diag_code,
    input logic              fault_n,
    input logic              mode_and
);

    p_uv_all_off_r6: assert property (@(posedge clk) disable iff (rst)
        uv_flag |=> (gate_en == '0));

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        p_ot_off_r5: assert property (@(posedge clk) disable iff (rst)
            ot_flag[i] |=> (!gate_en[i] && diag_code[2*i +: 2] == 2'b10));

        p_oc_overload_r7: assert property (@(posedge clk) disable iff (rst)
            oc_hi[i] |=> (diag_code[2*i +: 2] == 2'b10));

        p_sg_priority_r8: assert property (@(posedge clk) disable iff (rst)
            sg_flag[i] |=> (diag_code[2*i +: 2] == 2'b00 || diag_code[2*i +: 2] == 2'b10));

        p_fault_low_r11: assert property (@(posedge clk) disable iff (rst)
            oc_hi[i] |=> !fault_n);

        if (ch_has_par(i)) begin : g_par
            p_or_mode_r3: assert property (@(posedge clk) disable iff (rst)
                (!mode_and && spi_cmd[i] && !uv_flag && !ot_flag[i]) |=> gate_en[i]);
            p_and_mode_r4: assert property (@(posedge clk) disable iff (rst)
                (mode_and && !spi_cmd[i]) |=> !gate_en[i]);
        end else begin : g_spi
            p_spi_on_r2: assert property (@(posedge clk) disable iff (rst)
                (spi_cmd[i] && !uv_flag && !ot_flag[i]) |=> gate_en[i]);
            p_spi_off_r2: assert property (@(posedge clk) disable iff (rst)
                !spi_cmd[i] |=> !gate_en[i]);
        end
    end

endmodule

bind switch_bank_ctrl swb_checker #(.N_CH(N_CH)) u_swb_checker (
    .clk       (clk),
    .rst       (rst),
    .spi_cmd   (spi_cmd),
    .uv_flag   (uv_flag),
    .ot_flag   (ot_flag),
    .oc_hi     (oc_hi),
    .sg_flag   (sg_flag),
    .gate_en   (gate_en),
    .diag_code (diag_code),
    .fault_n   (fault_n),
    .mode_and  (mode_and)
);

// File: tb/test_switch_bank_ctrl.sv
`timescale 1ns/1ps
module test_switch_bank_ctrl;

    localparam int NC = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic [NC-1:0] spi_cmd;
    logic [7:0]    par_in;
    logic          mode_wr, mode_val, uv_flag, diag_rd;
    logic [0:0]    diag_grp;
    logic [NC-1:0] ot_flag, oc_hi, oc_lo, sg_flag, ol_flag;
    logic [NC-1:0] gate_en;
    logic [2*NC-1:0] diag_code;
    logic          fault_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    switch_bank_ctrl i_switch_bank_ctrl (
        .clk(clk), .rst(rst), .spi_cmd(spi_cmd), .par_in(par_in),
        .mode_wr(mode_wr), .mode_val(mode_val), .uv_flag(uv_flag),
        .ot_flag(ot_flag), .oc_hi(oc_hi), .oc_lo(oc_lo), .sg_flag(sg_flag),
        .ol_flag(ol_flag), .diag_rd(diag_rd), .diag_grp(diag_grp),
        .gate_en(gate_en), .diag_code(diag_code), .fault_n(fault_n)
    );

    // reference state
    bit         m_oc[NC], m_ovl[NC], m_sgh[NC], m_gate[NC];
    logic [1:0] m_code[NC];
    bit         m_mode;
    string      gtag[NC], ctag[NC];

    function automatic bit has_par(input int ch);
        return (ch % 8) < 4;
    endfunction

    function automatic int pidx(input int ch);
        return (ch / 8) * 4 + (ch % 8);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            for (int i = 0; i < NC; i++) begin
                m_oc[i] = 0; m_ovl[i] = 0; m_sgh[i] = 0; m_gate[i] = 0;
                m_code[i] = 2'b11; gtag[i] = "R1"; ctag[i] = "R1";
            end
            m_mode = 0;
        end else begin
            for (int i = 0; i < NC; i++) begin
                bit clr, cmd;
                clr = diag_rd && (diag_grp == 1'(i / 8));
                if (has_par(i))
                    cmd = m_mode ? (spi_cmd[i] & par_in[pidx(i)]) : (spi_cmd[i] | par_in[pidx(i)]);
                else
                    cmd = spi_cmd[i];
                m_gate[i] = cmd && !uv_flag && !ot_flag[i];
                gtag[i] = uv_flag ? "R6" : ot_flag[i] ? "R5" :
                          has_par(i) ? (m_mode ? "R4" : "R3") : "R2";
                if (oc_hi[i])       m_oc[i] = 1;
                else if (!oc_lo[i]) m_oc[i] = 0;
                m_ovl[i] = m_oc[i] || ot_flag[i] || (m_ovl[i] && !clr);
                m_sgh[i] = sg_flag[i] || (m_sgh[i] && !clr);
                if (m_ovl[i]) begin
                    m_code[i] = 2'b10;
                    ctag[i] = ot_flag[i] ? "R5" : (m_oc[i] ? "R7" : "R9");
                end else if (m_sgh[i]) begin
                    m_code[i] = 2'b00;
                    ctag[i] = sg_flag[i] ? "R8" : "R9";
                end else if (ol_flag[i]) begin
                    m_code[i] = 2'b01; ctag[i] = "R10";
                end else begin
                    m_code[i] = 2'b11; ctag[i] = "R10";
                end
            end
            if (mode_wr) m_mode = mode_val;
        end
    endtask

    task automatic check_all();
        bit all_ok;
        all_ok = 1;
        for (int i = 0; i < NC; i++) begin
            check(gate_en[i] == m_gate[i], gtag[i], 32'(gate_en[i]), 32'(m_gate[i]));
            check(diag_code[2*i +: 2] == m_code[i], ctag[i], 32'(diag_code[2*i +: 2]), 32'(m_code[i]));
            if (m_code[i] != 2'b11) all_ok = 0;
        end
        check(fault_n == all_ok, "R11", 32'(fault_n), 32'(all_ok));
    endtask

    // entered at a falling edge with inputs already driven
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    task automatic idle_inputs();
        spi_cmd = '0; par_in = '0; mode_wr = 0; mode_val = 0; uv_flag = 0;
        ot_flag = '0; oc_hi = '0; oc_lo = '0; sg_flag = '0; ol_flag = '0;
        diag_rd = 0; diag_grp = '0;
    endtask

    function automatic logic [NC-1:0] rand_bits(input int one_in);
        logic [NC-1:0] v;
        for (int i = 0; i < NC; i++) v[i] = ($urandom % one_in) == 0;
        return v;
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        idle_inputs();
        rst = 1;
        @(negedge clk);
        step();
        step();
        // R1: reset state
        check(gate_en == '0, "R1", 32'(gate_en), 0);
        check(diag_code == '1, "R1", diag_code, 32'hFFFF_FFFF);
        check(fault_n == 1'b1, "R1", 32'(fault_n), 1);
        rst = 0;
        step();
        // R1: mode is OR after reset (pin alone enables channel 1)
        par_in = 8'h01;
        step();
        check(gate_en[0] == 1'b1, "R1", 32'(gate_en[0]), 1);

        // R12: no output change before the edge
        par_in = '0; spi_cmd[5] = 1;
        #1;
        check(gate_en[5] == 1'b0 && gate_en[0] == 1'b1, "R12", 32'(gate_en[5]), 0);
        step();
        check(gate_en[5] == 1'b1 && gate_en[0] == 1'b0, "R12", 32'(gate_en[5]), 1);

        // R4: switch to AND; pin alone no longer enables
        mode_wr = 1; mode_val = 1; spi_cmd = '0; par_in = 8'h10;
        step();
        check(gate_en[8] == 1'b1, "R4", 32'(gate_en[8]), 1);  // OR still used this edge
        mode_wr = 0;
        step();
        check(gate_en[8] == 1'b0, "R4", 32'(gate_en[8]), 0);
        spi_cmd[8] = 1;
        step();
        check(gate_en[8] == 1'b1, "R4", 32'(gate_en[8]), 1);

        // R2: SPI-only channel ignores parallel pins
        par_in = 8'hFF; spi_cmd = '0;
        step();
        check(gate_en[4] == 1'b0 && gate_en[12] == 1'b0, "R2", 32'(gate_en), 0);

        // R5: thermal toggling on channel 9 (index 8)
        spi_cmd = 16'hFFFF; par_in = 8'hFF; ot_flag[8] = 1;
        step();
        check(gate_en[8] == 1'b0, "R5", 32'(gate_en[8]), 0);
        ot_flag[8] = 0;
        step();
        check(gate_en[8] == 1'b1, "R5", 32'(gate_en[8]), 1);

        // R6: undervoltage
        uv_flag = 1;
        step();
        check(gate_en == '0, "R6", 32'(gate_en), 0);
        uv_flag = 0;
        diag_rd = 1; diag_grp = 1;  // clear thermal report of channel 9
        step();
        diag_rd = 0;

        // R7 and R9: hysteresis, latch and group clear on channel 1
        oc_hi[0] = 1; oc_lo[0] = 1;
        step();
        check(diag_code[1:0] == 2'b10 && !fault_n, "R7", 32'(diag_code[1:0]), 2);
        oc_hi[0] = 0; diag_rd = 1; diag_grp = 0;
        step();
        check(diag_code[1:0] == 2'b10, "R7", 32'(diag_code[1:0]), 2);
        oc_lo[0] = 0; diag_rd = 1; diag_grp = 1;
        step();
        check(diag_code[1:0] == 2'b10, "R9", 32'(diag_code[1:0]), 2);
        diag_grp = 0;
        step();
        check(diag_code[1:0] == 2'b11 && fault_n, "R9", 32'(diag_code[1:0]), 3);
        diag_rd = 0;

        // R8: priority; R10: open load follows flag
        sg_flag[3] = 1; ol_flag[3] = 1;
        step();
        check(diag_code[7:6] == 2'b00, "R8", 32'(diag_code[7:6]), 0);
        sg_flag[3] = 0; diag_rd = 1; diag_grp = 0;
        step();
        check(diag_code[7:6] == 2'b01, "R10", 32'(diag_code[7:6]), 1);
        diag_rd = 0; ol_flag[3] = 0;
        step();
        check(diag_code[7:6] == 2'b11, "R10", 32'(diag_code[7:6]), 3);

        // constrained random phase
        for (int n = 0; n < 3000; n++) begin
            spi_cmd  = 16'($urandom);
            par_in   = 8'($urandom);
            mode_wr  = ($urandom % 16) == 0;
            mode_val = 1'($urandom);
            uv_flag  = ($urandom % 32) == 0;
            ot_flag  = rand_bits(12);
            oc_hi    = rand_bits(10);
            oc_lo    = oc_hi | rand_bits(2);
            sg_flag  = rand_bits(12);
            ol_flag  = rand_bits(6);
            diag_rd  = ($urandom % 4) == 0;
            diag_grp = 1'($urandom);
            rst      = ($urandom % 1000) == 0;
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule